// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This stage sits in a digital audio path and scales every sample of a multichannel frame by one gain factor, shared by all channels. The gain is a step counter that moves by one step on each frame strobe. When the mute request is high it walks down toward silence, and when the request is low it walks back up toward unity. A full transition in either direction takes 2^STEP_LOG2 frames, which is 1024 with the default parameters. The output never jumps, because the request may change level at any point in a ramp.

Each output sample is the input sample multiplied by count/2^STEP_LOG2. The product is signed and the division is an arithmetic right shift, so at the ends of the range the result is exact. A count of zero gives a silent output, and a full count passes the input through unchanged.

A status flag rises once the counter has reached zero, so that the rest of the path can tell that silence is complete. Volume setting, filtering and conversion to analog are handled by other blocks.

Top module: `soft_mute_ramp`

## Requirements
- R1: After synchronous reset the counter is at full scale (1024), `muted` is low and every output sample is zero.
- R2: On each `frame_stb` with `mute_req` high and a nonzero counter, the counter decreases by exactly one. From full scale, the counter reaches zero on the 1024th such strobe.
- R3: On each `frame_stb` with `mute_req` low and the counter below full scale, the counter increases by exactly one. From zero, it reaches full scale on the 1024th such strobe.
- R4: If `mute_req` drops during a fall, the next strobe raises the counter by one from its present value. The counter never changes by more than one step per strobe.
- R5: If `mute_req` rises during a rise, the counter descends on the very next strobe.
- R6: On a strobe, channel k of `dout` (bits k*24+23 down to k*24) becomes (signed input of channel k × new count) >>> 10, an arithmetic shift. The same count applies to every channel.
- R7: When the count is 0 every output is exactly zero. When the count is 1024 every output equals its input bit for bit.
- R8: `muted` is high exactly when the counter is at zero, and it is updated together with the outputs.
- R9: Without `frame_stb`, the counter, `dout` and `muted` hold their values whatever `din` and `mute_req` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse per audio frame; advances ramp and loads outputs |
| mute_req | input | 1 | High requests silence, low requests unity gain |
| din | input | NCH*DW | Packed signed input samples, channel 0 in the low bits |
| dout | output | NCH*DW | Packed signed scaled samples, registered |
| muted | output | 1 | High while the gain counter sits at zero |

## Verification
The assertions assume that `frame_stb` is held low during reset, and that `din` is sampled only on the cycle in which the strobe is high. The bench honours this by driving the strobe as a single-cycle pulse, launched away from the clock edge, and by keeping it low for the whole of reset. Between strobes it inserts random idle gaps during which `din` and `mute_req` keep changing. These changes exercise the hold behaviour without breaking the sampling assumption. Directed phases load a constant input of 1024, so the output reads back the count directly. This makes it possible to check the turnaround points of the ramp.

// File: rtl/smr_pkg.sv
package smr_pkg;
  // Direction the gain counter takes on a strobe
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_UP   = 2'd2
  } ramp_dir_t;
endpackage

// File: rtl/smr_gain_ctr.sv
module smr_gain_ctr
  import smr_pkg::*;
#(
  parameter int STEP_LOG2 = 10,
  localparam int CW = STEP_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_stb,
  input  logic          mute_req,
  output logic [CW-1:0] cnt_next,
  output logic [CW-1:0] cnt_q,
  output logic          muted_q
);
  localparam logic [CW-1:0] FULL = {1'b1, {STEP_LOG2{1'b0}}};
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  ramp_dir_t dir;

  always_comb begin
    dir = DIR_HOLD;
    if (frame_stb) begin
      if (mute_req && (cnt_q != '0))
        dir = DIR_DOWN;
      else if (!mute_req && (cnt_q != FULL))
        dir = DIR_UP;
    end
  end

  always_comb begin
    unique case (dir)
      DIR_DOWN: cnt_next = cnt_q - ONE;
      DIR_UP:   cnt_next = cnt_q + ONE;
      default:  cnt_next = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= FULL;
      muted_q <= 1'b0;
    end else if (frame_stb) begin
      cnt_q   <= cnt_next;
      muted_q <= (cnt_next == '0);
    end
  end
endmodule

// File: rtl/smr_scale.sv
module smr_scale #(
  parameter int DW        = 24,
  parameter int STEP_LOG2 = 10,
  localparam int CW = STEP_LOG2 + 1,
  localparam int PW = DW + CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] sample,
  input  logic [CW-1:0] gain,
  output logic [DW-1:0] scaled
);
  logic signed [PW-1:0] s_ext;
  logic signed [PW-1:0] g_ext;
  logic signed [PW-1:0] prod;

  always_comb begin
    s_ext = {{(PW-DW){sample[DW-1]}}, sample};
    g_ext = {{(PW-CW){1'b0}}, gain};
    prod  = s_ext * g_ext;
  end

  always_ff @(posedge clk) begin
    if (rst)
      scaled <= '0;
    else if (load)
      scaled <= DW'(prod >>> STEP_LOG2);
  end
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int NCH       = 2,
  parameter int DW        = 24,
  parameter int STEP_LOG2 = 10,
  localparam int CW = STEP_LOG2 + 1,
  localparam int BW = NCH * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_stb,
  input  logic          mute_req,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] dout,
  output logic          muted
);
  logic [CW-1:0] gain_next;
  logic [CW-1:0] gain_cnt;

  smr_gain_ctr #(.STEP_LOG2(STEP_LOG2)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .frame_stb(frame_stb),
    .mute_req (mute_req),
    .cnt_next (gain_next),
    .cnt_q    (gain_cnt),
    .muted_q  (muted)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    smr_scale #(.DW(DW), .STEP_LOG2(STEP_LOG2)) u_scale (
      .clk   (clk),
      .rst   (rst),
      .load  (frame_stb),
      .sample(din[ch*DW +: DW]),
      .gain  (gain_next),
      .scaled(dout[ch*DW +: DW])
    );
  end
endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
  parameter int NCH       = 2,
  parameter int DW        = 24,
  parameter int STEP_LOG2 = 10,
  localparam int CW = STEP_LOG2 + 1,
  localparam int BW = NCH * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_stb,
  input logic          mute_req,
  input logic [BW-1:0] din,
  input logic [BW-1:0] dout,
  input logic          muted,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] FULL = {1'b1, {STEP_LOG2{1'b0}}};
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  p_range_r2: assert property (@(posedge clk) disable iff (rst) cnt <= FULL);

  p_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && mute_req && cnt != '0) |=> cnt == $past(cnt) - ONE);

  p_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !mute_req && cnt != FULL) |=> cnt == $past(cnt) + ONE);

  p_one_step_r4: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> (cnt == $past(cnt) || cnt == $past(cnt) + ONE || cnt + ONE == $past(cnt)));

  p_silent_r7: assert property (@(posedge clk) disable iff (rst) muted |-> dout == '0);

  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !mute_req && cnt == FULL) |=> dout == $past(din));

  p_mute_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(muted) |-> ($past(frame_stb) && $past(mute_req)));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> ($stable(cnt) && $stable(dout) && $stable(muted)));
endmodule

bind soft_mute_ramp smr_checker #(.NCH(NCH), .DW(DW), .STEP_LOG2(STEP_LOG2)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .frame_stb(frame_stb),
  .mute_req (mute_req),
  .din      (din),
  .dout     (dout),
  .muted    (muted),
  .cnt      (gain_cnt)
);

// File: tb/sim_soft_mute_ramp.sv
module sim_soft_mute_ramp;
  localparam int NCH  = 2;
  localparam int DW   = 24;
  localparam int LOG2 = 10;
  localparam int FULL = 1 << LOG2;
  localparam int BW   = NCH * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_stb = 1'b0;
  logic          mute_req = 1'b0;
  logic [BW-1:0] din = '0;
  logic [BW-1:0] dout;
  logic          muted;

  int n_chk  = 0;
  int n_fail = 0;
  int cnt_m  = FULL;
  logic [BW-1:0] last_dout;

  always #10 clk = ~clk;  // 50 MHz

  soft_mute_ramp #(.NCH(NCH), .DW(DW), .STEP_LOG2(LOG2)) u0 (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .mute_req(mute_req),
    .din(din), .dout(dout), .muted(muted)
  );

  function automatic logic [DW-1:0] exp_out(logic [DW-1:0] s, int c);
    longint v;
    v = longint'($signed(s)) * longint'(c);
    return DW'(v >>> LOG2);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_frame(logic [BW-1:0] src, string req);
    for (int ch = 0; ch < NCH; ch++) begin
      logic [DW-1:0] e;
      e = exp_out(src[ch*DW +: DW], cnt_m);
      check(dout[ch*DW +: DW] == e, req, $signed(dout[ch*DW +: DW]), $signed(e));
    end
    check(muted == (cnt_m == 0), "R8", muted, cnt_m == 0);
  endtask

  // one strobe, then compare outputs on the following falling edge
  task automatic strobe(bit m, logic [BW-1:0] src, string req);
    @(negedge clk);
    mute_req  = m;
    din       = src;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    if (m && cnt_m > 0) cnt_m--;
    else if (!m && cnt_m < FULL) cnt_m++;
    check_frame(src, req);
  endtask

  function automatic logic [BW-1:0] rnd_frame();
    logic [BW-1:0] f;
    for (int ch = 0; ch < NCH; ch++) f[ch*DW +: DW] = DW'($urandom);
    return f;
  endfunction

  function automatic logic [BW-1:0] const_frame(int v);
    logic [BW-1:0] f;
    for (int ch = 0; ch < NCH; ch++) f[ch*DW +: DW] = DW'(v);
    return f;
  endfunction

  initial begin
    #4000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(dout == '0, "R1", dout, 0);
    check(muted == 1'b0, "R1", muted, 0);

    // R7: unity gain passes input bit for bit, including negatives
    strobe(1'b0, rnd_frame(), "R7");
    strobe(1'b0, const_frame(-1), "R7");
    check(dout == const_frame(-1), "R7", dout[DW-1:0], -1);

    // R2: full fall, watching count through a constant input of 1024
    for (int i = 1; i <= FULL; i++) begin
      strobe(1'b1, (i % 3 == 0) ? rnd_frame() : const_frame(FULL), "R2");
      if (i == FULL - 1) check(muted == 1'b0, "R2", muted, 0);
    end
    check(muted == 1'b1, "R2", muted, 1);
    // R7: zero count silences any input
    strobe(1'b1, const_frame(-8388608), "R7");
    check(dout == '0, "R7", dout[DW-1:0], 0);

    // R3: full rise
    for (int i = 1; i <= FULL; i++) strobe(1'b0, rnd_frame(), "R3");
    strobe(1'b0, const_frame(FULL), "R3");
    check(dout[DW-1:0] == DW'(FULL), "R3", dout[DW-1:0], FULL);

    // R4: release after 300 falling steps turns the ramp around
    for (int i = 0; i < 300; i++) strobe(1'b1, const_frame(FULL), "R4");
    check(dout[DW-1:0] == DW'(FULL - 300), "R4", dout[DW-1:0], FULL - 300);
    strobe(1'b0, const_frame(FULL), "R4");
    check(dout[DW-1:0] == DW'(FULL - 299), "R4", dout[DW-1:0], FULL - 299);

    // R5: reassert during the rise descends on the next strobe
    for (int i = 0; i < 50; i++) strobe(1'b0, const_frame(FULL), "R5");
    strobe(1'b1, const_frame(FULL), "R5");
    check(dout[DW-1:0] == DW'(FULL - 250), "R5", dout[DW-1:0], FULL - 250);

    // R6/R9: random frames, random mute changes, random idle gaps
    for (int i = 0; i < 4000; i++) begin
      bit m;
      int gap;
      m = (($urandom % 500) < 6) ? ~mute_req : mute_req;
      strobe(m, rnd_frame(), "R6");
      gap = $urandom % 3;
      last_dout = dout;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        din      = rnd_frame();
        mute_req = $urandom % 2;
      end
      if (gap > 0) begin
        @(negedge clk);
        check(dout == last_dout, "R9", dout[DW-1:0], last_dout[DW-1:0]);
        check(muted == (cnt_m == 0), "R9", muted, cnt_m == 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule